// File: doc/BRIEF.md
# Edge-Sense Interrupt Latch

This block monitors twenty-four input pins, grouped as three eight-bit ports. Each pin has its own polarity bit and its own enable bit. When an enabled pin shows a transition in the selected direction, a sticky identification flag is set for that pin. Any set flag raises one shared interrupt request to the host. A three-bit summary shows which ports hold at least one pending flag. Software can then read only the ports that matter.

The pins are asynchronous. Each pin passes through a two-stage synchronizer, and a transition is found by comparing the synchronized level with the level one clock earlier. Rising and falling refer to the physical pin level.

A separate register interface block does address decoding and paging. It drives this block with per-port write strobes and one shared write-data byte. A write strobe for a port's flag register clears all eight flags of that port, and the data byte is ignored. Turning off a pin's enable bit also clears that pin's flag.

Top module: `edge_irq_latch`

## Requirements
- R1: While reset is asserted, and until writes follow it, all polarity bits, enable bits and flags are 0. In that state `flags_o` = 0, `summary_o` = 0 and `irq_o` = 0.
- R2: With polarity bit 1 and enable bit 1, a low-to-high change on a pin sets that pin's flag. The pin is driven before clock edge k, and the flag shows in `flags_o` after edge k+2, not earlier. Flag bit 8*p+b belongs to `pin_i` bit 8*p+b.
- R3: With polarity bit 0 and enable bit 1, a high-to-low change on a pin sets its flag. A low-to-high change on that pin does not set it.
- R4: A pin whose enable bit is 0 never sets its flag, whatever its pin does.
- R5: Once set, a flag stays at 1 until one of two things clears it: a flag-clear strobe for its port, or its enable bit going to 0.
- R6: A clock with `clr_wr_i[p]` = 1 clears all eight flags of port p, whatever `wdata_i` holds. Flags of the other ports do not change.
- R7: Writing 0 to a pin's enable bit clears its flag in that same clock. Writing the enable bit back to 1 leaves the flag clear.
- R8: If a qualifying transition on a pin is detected in the same clock as the clear strobe for its port, that pin's flag ends up set. The other flags of the port are cleared.
- R9: `summary_o` bit p (p = 0..2) is 1 exactly when any flag of port p is 1. Bits 7:3 are always 0.
- R10: `irq_o` is 1 exactly when any of the 24 flags is 1.
- R11: `pol_wr_i[p]` loads `wdata_i` into port p's eight polarity bits, and `en_wr_i[p]` loads it into port p's eight enable bits. Bit b of `wdata_i` controls pin 8*p+b. Other ports' settings do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 24 | Raw pin levels, port p at bits 8p+7:8p |
| pol_wr_i | input | 3 | Per-port polarity register write strobe |
| en_wr_i | input | 3 | Per-port enable register write strobe |
| clr_wr_i | input | 3 | Per-port flag register write strobe (clears that port's flags) |
| wdata_i | input | 8 | Write data for polarity and enable writes |
| flags_o | output | 24 | Latched flags |
| summary_o | output | 8 | Per-port pending summary, bits 7:3 zero |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is R8: a qualifying transition detected in exactly the clock where its port's clear strobe is sampled. From the ports, this clock lies two edges after the pin change. The directed part of the bench counts those edges and drives the clear strobe at that point. It has already set a second flag in the same port, so one run shows both outcomes: the new flag survives and the old flag is cleared.

The random phase also hits this coincidence and the disable-versus-transition coincidence by chance. It toggles pins on every cycle, drives every strobe with random data, and compares every output against a cycle-level model in the bench.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int unsigned NUM_PORTS = 3;
  localparam int unsigned PORT_W    = 8;
  localparam int unsigned NUM_PINS  = NUM_PORTS * PORT_W;
  localparam int unsigned SYNC_LEN  = 2;

  typedef logic [PORT_W-1:0] port_vec_t;
endpackage

// File: rtl/eil_reset_sync.sv
module eil_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/eil_pin_sync.sv
module eil_pin_sync #(
  parameter int unsigned WIDTH  = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] stage_d;
    logic              prev_q;

    always_comb begin
      stage_d = {stage_q[STAGES-2:0], pin_i[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        stage_q <= stage_d;
        prev_q  <= stage_q[STAGES-1];
      end
    end

    assign cur_o[i]  = stage_q[STAGES-1];
    assign prev_o[i] = prev_q;
  end
endmodule

// File: rtl/eil_port_slice.sv
module eil_port_slice
  import edge_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  port_vec_t cur_i,
  input  port_vec_t prev_i,
  input  logic      pol_wr_i,
  input  logic      en_wr_i,
  input  logic      clr_wr_i,
  input  port_vec_t wdata_i,
  output port_vec_t flags_o,
  output port_vec_t en_o,
  output port_vec_t hit_o
);
  port_vec_t pol_q, pol_d;
  port_vec_t en_q,  en_d;
  port_vec_t flg_q, flg_d;
  port_vec_t rise, fall, hit;

  always_comb begin
    rise  = cur_i & ~prev_i;
    fall  = ~cur_i & prev_i;
    hit   = ((pol_q & rise) | (~pol_q & fall)) & en_q;
    pol_d = pol_wr_i ? wdata_i : pol_q;
    en_d  = en_wr_i  ? wdata_i : en_q;
    flg_d = en_d & (hit | (flg_q & ~{PORT_W{clr_wr_i}}));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      en_q  <= '0;
      flg_q <= '0;
    end else begin
      pol_q <= pol_d;
      en_q  <= en_d;
      flg_q <= flg_d;
    end
  end

  assign flags_o = flg_q;
  assign en_o    = en_q;
  assign hit_o   = hit;
endmodule

// File: rtl/edge_irq_latch.sv
module edge_irq_latch
  import edge_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  pin_i,
  input  logic [NUM_PORTS-1:0] pol_wr_i,
  input  logic [NUM_PORTS-1:0] en_wr_i,
  input  logic [NUM_PORTS-1:0] clr_wr_i,
  input  logic [PORT_W-1:0]    wdata_i,
  output logic [NUM_PINS-1:0]  flags_o,
  output logic [PORT_W-1:0]    summary_o,
  output logic                 irq_o
);
  logic                 rst_n_sync;
  logic [NUM_PINS-1:0]  cur, prev;
  logic [NUM_PINS-1:0]  en_all, hit_all;
  logic [NUM_PORTS-1:0] port_any;

  eil_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  eil_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n_sync), .pin_i(pin_i), .cur_o(cur), .prev_o(prev)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    eil_port_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .cur_i    (cur[p*PORT_W +: PORT_W]),
      .prev_i   (prev[p*PORT_W +: PORT_W]),
      .pol_wr_i (pol_wr_i[p]),
      .en_wr_i  (en_wr_i[p]),
      .clr_wr_i (clr_wr_i[p]),
      .wdata_i  (wdata_i),
      .flags_o  (flags_o[p*PORT_W +: PORT_W]),
      .en_o     (en_all[p*PORT_W +: PORT_W]),
      .hit_o    (hit_all[p*PORT_W +: PORT_W])
    );
    assign port_any[p] = |flags_o[p*PORT_W +: PORT_W];
  end

  always_comb begin
    summary_o = '0;
    summary_o[NUM_PORTS-1:0] = port_any;
  end

  assign irq_o = |port_any;
endmodule

// File: rtl/edge_irq_latch_chk.sv
module edge_irq_latch_chk
  import edge_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PINS-1:0]  flags_o,
  input logic [PORT_W-1:0]    summary_o,
  input logic                 irq_o,
  input logic [NUM_PORTS-1:0] clr_wr_i,
  input logic [NUM_PINS-1:0]  en_all,
  input logic [NUM_PINS-1:0]  hit_all
);
  logic [NUM_PINS-1:0] clr_mask;
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_m
    assign clr_mask[p*PORT_W +: PORT_W] = {PORT_W{clr_wr_i[p]}};
  end

  // R10
  irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (flags_o != '0));

  // R9
  summary_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    summary_o[PORT_W-1:NUM_PORTS] == '0);

  // R7
  disabled_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & ~en_all) == '0);

  // R5
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flags_o) & ~flags_o & en_all & ~$past(clr_mask)) == '0);

  // R6
  clear_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i != '0) |=> ((flags_o & $past(clr_mask) & ~$past(hit_all)) == '0));

  // R8
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_all & clr_mask) != '0) |=> (($past(hit_all & clr_mask) & en_all & ~flags_o) == '0));
endmodule

bind edge_irq_latch edge_irq_latch_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .flags_o   (flags_o),
  .summary_o (summary_o),
  .irq_o     (irq_o),
  .clr_wr_i  (clr_wr_i),
  .en_all    (en_all),
  .hit_all   (hit_all)
);

// File: tb/edge_irq_latch_tb.sv
`timescale 1ns/1ps
module edge_irq_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pin_i = '0;
  logic [2:0]  pol_wr_i = '0, en_wr_i = '0, clr_wr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [23:0] flags_o;
  logic [7:0]  summary_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  edge_irq_latch dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pol_wr_i(pol_wr_i),
    .en_wr_i(en_wr_i), .clr_wr_i(clr_wr_i), .wdata_i(wdata_i),
    .flags_o(flags_o), .summary_o(summary_o), .irq_o(irq_o)
  );

  // Reference model of the requirements, stepped on each rising edge
  logic [23:0] m_s1, m_s2, m_prev, m_pol, m_en, m_flg;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pol = '0; m_en = '0; m_flg = '0;
    end else begin
      logic [23:0] det, nen, clrm;
      det  = ((m_pol & m_s2 & ~m_prev) | (~m_pol & ~m_s2 & m_prev)) & m_en;
      nen  = m_en;
      clrm = '0;
      for (int p = 0; p < 3; p++) begin
        if (pol_wr_i[p]) m_pol[p*8 +: 8] = wdata_i;
        if (en_wr_i[p])  nen[p*8 +: 8]  = wdata_i;
        if (clr_wr_i[p]) clrm[p*8 +: 8] = 8'hFF;
      end
      m_flg  = nen & (det | (m_flg & ~clrm));
      m_en   = nen;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pin_i;
    end
  end

  function automatic logic [7:0] exp_summary(input logic [23:0] f);
    return {5'b0, |f[23:16], |f[15:8], |f[7:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] pw, input logic [2:0] ew,
                    input logic [2:0] cw, input logic [7:0] d);
    pol_wr_i = pw; en_wr_i = ew; clr_wr_i = cw; wdata_i = d;
    tick();
    pol_wr_i = '0; en_wr_i = '0; clr_wr_i = '0; wdata_i = '0;
  endtask

  initial begin
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    tick(3);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk("R1 flags", flags_o, 0);
    chk("R1 summary", summary_o, 0);
    chk("R1 irq", irq_o, 0);

    // R2 rising edge, R11 port 0 settings
    wr(3'b001, 3'b000, 3'b000, 8'hFF);
    wr(3'b000, 3'b001, 3'b000, 8'hFF);
    pin_i[0] = 1'b1;
    tick(2);
    chk("R2 latency", flags_o, 0);
    tick(1);
    chk("R2 rise", flags_o, 24'h000001);
    chk("R9 summary", summary_o, 8'h01);
    chk("R10 irq", irq_o, 1);

    // R5 sticky through opposite edge and idle time
    pin_i[0] = 1'b0;
    tick(10);
    chk("R5 sticky", flags_o, 24'h000001);

    // R6 clear port 0 with zero data
    wr(3'b000, 3'b000, 3'b001, 8'h00);
    chk("R6 clear", flags_o, 0);
    chk("R10 irq low", irq_o, 0);

    // R3 falling polarity on port 1
    wr(3'b000, 3'b010, 3'b000, 8'hFF);
    pin_i[9] = 1'b1;
    tick(4);
    chk("R3 rise ignored", flags_o, 0);
    pin_i[9] = 1'b0;
    tick(3);
    chk("R3 fall", flags_o, 24'h000200);
    chk("R9 port1", summary_o, 8'h02);

    // R4 / R11 partial enable on port 2
    wr(3'b100, 3'b100, 3'b000, 8'h0F);
    wr(3'b100, 3'b000, 3'b000, 8'hFF);
    pin_i[23:16] = 8'hFF;
    tick(3);
    chk("R4 disabled bits", flags_o[23:16], 8'h0F);
    chk("R9 two ports", summary_o, 8'h06);

    // R6 clear port 2 with nonzero data, port 1 untouched
    wr(3'b000, 3'b000, 3'b100, 8'hAB);
    chk("R6 isolation", flags_o, 24'h000200);

    // R7 disable clears, re-enable keeps clear
    wr(3'b000, 3'b010, 3'b000, 8'h00);
    chk("R7 disable", flags_o, 0);
    wr(3'b000, 3'b010, 3'b000, 8'hFF);
    tick(2);
    chk("R7 reenable", flags_o, 0);

    // R8 edge coincident with clear on port 0
    pin_i[0] = 1'b1;
    tick(3);
    chk("R8 setup", flags_o[7:0], 8'h01);
    pin_i[3] = 1'b1;
    tick(2);
    wr(3'b000, 3'b000, 3'b001, 8'h5A);
    chk("R8 edge wins", flags_o[7:0], 8'h08);

    // Random phase against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom();
      pin_i    = pin_i ^ ($urandom() & $urandom() & 24'hFFFFFF);
      pol_wr_i = (r[3:0] == 0) ? r[6:4]   : 3'b0;
      en_wr_i  = (r[10:7] == 0) ? r[13:11] : 3'b0;
      clr_wr_i = (r[17:14] == 0) ? r[20:18] : 3'b0;
      wdata_i  = r[31:24];
      tick();
      chk("R2 R3 R4 R5 R6 R7 R8 R11 random flags", flags_o, m_flg);
      chk("R9 random summary", summary_o, exp_summary(m_flg));
      chk("R10 random irq", irq_o, |m_flg);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule